// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Controller

The controller gathers a set of level-sensitive peripheral interrupt lines and steers each one toward one or more CPUs. A single request port carries both a global bank (source enables and per-source routing) and a per-CPU bank (masking and acknowledge). Which per-CPU bank is reached depends on the CPU number presented with the request. Enables and masks are never changed by read-modify-write. Software writes a source number to a dedicated set or clear location instead, so two CPUs never race on a shared bitmap.

Every CPU has one interrupt output and one acknowledge location. The acknowledge location returns the lowest-numbered source that is pending for that CPU, or 1023 when nothing is pending. Source 0 is reserved for doorbell events. These arrive on a per-CPU input from a separate block and always win. Source 5 is a private per-CPU source, such as a local timer. It has its own per-CPU input and is gated only by that CPU's mask. Reading the acknowledge location has no side effect, because sources are level-sensitive: a source stays pending for as long as its line stays high.

Address bit 12 selects the bank: 0 for global and 1 for per-CPU. Offsets within a bank are given by address bits [11:0]. Write data bits [9:0] carry a source number.

Top module: `mcic_core`

## Requirements
- R1: After reset every source is disabled, unrouted and masked for every CPU. All `cpu_irq` outputs are low, every acknowledge read returns 1023, and a read of global offset 0x000 returns the number of implemented sources in bits [11:2], with all other bits zero.
- R2: A write to global offset 0x030 sets the global enable of the source numbered in wdata[9:0]. A write to 0x034 clears it. Numbers at or above the source count, and number 0, are ignored.
- R3: A write to per-CPU offset 0x048 masks the named source for the requesting CPU only. A write to 0x04C unmasks it for that CPU only. The masks of other CPUs are unchanged.
- R4: The routing register of source n sits at global offset 0x100 + 4*n. Bit c of that register routes the source to CPU c. A read returns the stored bitmap in bits [NUM_CPU-1:0] and zero elsewhere.
- R5: An ordinary source s (not 0 and not 5) is pending for CPU c only when all four of these hold: its line is high, it is globally enabled, bit c of its routing register is set, and it is unmasked for c.
- R6: A read of per-CPU offset 0x044 returns, in bits [9:0], the lowest-numbered source pending for the requesting CPU, or 1023 if none is pending. Upper bits are zero. The read changes no state, so repeating it returns the same value.
- R7: When the doorbell input of a CPU is high, source 0 is pending for that CPU, and the acknowledge read returns 0 ahead of any other pending source.
- R8: Source 5 is pending for CPU c when the private input of c is high and source 5 is unmasked for c. The global enable, the routing register and the shared line of source 5 have no effect.
- R9: `cpu_irq[c]` is high when any source is pending for CPU c. It is registered and follows the pending state one clock edge later.
- R10: `req_ready` is always high. Every accepted request produces `rsp_valid` exactly one cycle later. A write takes effect at the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | NUM_SRC | Level interrupt lines of the shared sources |
| local_line | input | NUM_CPU | Private source-5 line of each CPU |
| bell_line | input | NUM_CPU | Doorbell pending line of each CPU (source 0) |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready (always high) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cpu | input | CPU_W | Number of the requesting CPU, which selects the banked registers |
| req_addr | input | 13 | Bit 12 selects the bank; bits [11:0] give the offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after a request is accepted |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| cpu_irq | output | NUM_CPU | Level interrupt output of each CPU |

## Verification
A register write is applied at the edge that accepts it. The interrupt output reflects that write one edge later, so it is due two edges after the write is driven. A line or doorbell change reaches `cpu_irq` at the first edge. Read data appears at the edge that accepts the read. The bench therefore drives on falling edges and samples on falling edges. It checks `cpu_irq` exactly one edge after a write edge (still old) and two edges after (new), and exactly one edge after a line change. Acknowledge values are compared against a bench model only after the pending state has settled.

// File: rtl/mcic_pkg.sv
package mcic_pkg;

    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

    localparam logic [11:0] OFF_CTRL     = 12'h000;
    localparam logic [11:0] OFF_EN_SET   = 12'h030;
    localparam logic [11:0] OFF_EN_CLR   = 12'h034;
    localparam logic [11:0] OFF_ACK      = 12'h044;
    localparam logic [11:0] OFF_MSK_SET  = 12'h048;
    localparam logic [11:0] OFF_MSK_CLR  = 12'h04C;
    localparam logic [11:0] OFF_SRC_BASE = 12'h100;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_MSK_SET,
        OP_MSK_CLR,
        OP_ROUTE
    } wr_op_e;

    typedef enum logic [1:0] {
        RD_ZERO,
        RD_CTRL,
        RD_ACK,
        RD_ROUTE
    } rd_sel_e;

    typedef struct packed {
        wr_op_e          wop;
        rd_sel_e         rsel;
        logic [ID_W-1:0] aidx;
    } req_dec_t;

    function automatic req_dec_t decode_req(logic [12:0] addr, logic wr);
        req_dec_t   d;
        logic [11:0] off;
        off    = addr[11:0];
        d.wop  = OP_NONE;
        d.rsel = RD_ZERO;
        d.aidx = off[11:2] - 10'h040;
        if (!addr[12]) begin
            if (off == OFF_CTRL) begin
                d.rsel = RD_CTRL;
            end else if (off >= OFF_SRC_BASE) begin
                d.rsel = RD_ROUTE;
                if (wr) d.wop = OP_ROUTE;
            end else if (off == OFF_EN_SET) begin
                if (wr) d.wop = OP_EN_SET;
            end else if (off == OFF_EN_CLR) begin
                if (wr) d.wop = OP_EN_CLR;
            end
        end else begin
            if (off == OFF_ACK) begin
                d.rsel = RD_ACK;
            end else if (off == OFF_MSK_SET) begin
                if (wr) d.wop = OP_MSK_SET;
            end else if (off == OFF_MSK_CLR) begin
                if (wr) d.wop = OP_MSK_CLR;
            end
        end
        if (wr) d.rsel = RD_ZERO;
        return d;
    endfunction

endpackage

// File: rtl/mcic_regs.sv
module mcic_regs
    import mcic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  wr_op_e                            wop,
    input  logic [ID_W-1:0]                   widx,
    input  logic [CPU_W-1:0]                  wcpu,
    input  logic [NUM_CPU-1:0]                wroute,
    output logic [NUM_SRC-1:0]                en_q,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_q,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_q
);

    logic             in_range;
    logic [SRC_W-1:0] sidx;

    assign in_range = int'(widx) < NUM_SRC;
    assign sidx     = widx[SRC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            route_q <= '0;
            mask_q  <= '1;
        end else if (in_range) begin
            unique case (wop)
                OP_EN_SET:  if (widx != '0) en_q[sidx] <= 1'b1;
                OP_EN_CLR:  if (widx != '0) en_q[sidx] <= 1'b0;
                OP_MSK_SET: mask_q[wcpu][sidx] <= 1'b1;
                OP_MSK_CLR: mask_q[wcpu][sidx] <= 1'b0;
                OP_ROUTE:   route_q[sidx] <= wroute;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mcic_pend.sv
module mcic_pend
    import mcic_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_CPU   = 4,
    parameter int CPU_IDX   = 0,
    parameter int LOCAL_SRC = 5
) (
    input  logic [NUM_SRC-1:0]               src_line,
    input  logic                             local_in,
    input  logic                             bell_in,
    input  logic [NUM_SRC-1:0]               en_q,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0]  route_q,
    input  logic [NUM_SRC-1:0]               mask_row,
    output logic                             pend_any,
    output logic [ID_W-1:0]                  ack_id
);

    logic [NUM_SRC-1:0] pend;

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            if (s == 0)
                pend[s] = bell_in;
            else if (s == LOCAL_SRC)
                pend[s] = local_in & ~mask_row[s];
            else
                pend[s] = src_line[s] & en_q[s] & route_q[s][CPU_IDX] & ~mask_row[s];
        end
    end

    always_comb begin
        ack_id = ID_NONE;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (pend[s]) ack_id = ID_W'(s);
        end
    end

    assign pend_any = |pend;

endmodule

// File: rtl/mcic_core.sv
module mcic_core
    import mcic_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_CPU   = 4,
    parameter int LOCAL_SRC = 5,
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_line,
    input  logic [NUM_CPU-1:0] local_line,
    input  logic [NUM_CPU-1:0] bell_line,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [CPU_W-1:0]   req_cpu,
    input  logic [12:0]        req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);

    req_dec_t                              dec;
    wr_op_e                                wop;
    logic [ID_W-1:0]                       widx;
    logic [NUM_SRC-1:0]                    en_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]       route_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]       mask_q;
    logic [NUM_CPU-1:0]                    pend_any;
    logic [NUM_CPU-1:0][ID_W-1:0]          ack_ids;
    logic [31:0]                           rd_mux;
    logic                                  rsp_valid_q;
    logic [31:0]                           rsp_data_q;
    logic [NUM_CPU-1:0]                    irq_q;

    assign req_ready = 1'b1;
    assign dec  = decode_req(req_addr, req_write);
    assign wop  = req_valid ? dec.wop : OP_NONE;
    assign widx = (dec.wop == OP_ROUTE) ? dec.aidx : req_wdata[ID_W-1:0];

    mcic_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wop     (wop),
        .widx    (widx),
        .wcpu    (req_cpu),
        .wroute  (req_wdata[NUM_CPU-1:0]),
        .en_q    (en_q),
        .route_q (route_q),
        .mask_q  (mask_q)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        mcic_pend #(
            .NUM_SRC   (NUM_SRC),
            .NUM_CPU   (NUM_CPU),
            .CPU_IDX   (c),
            .LOCAL_SRC (LOCAL_SRC)
        ) u_pend (
            .src_line (src_line),
            .local_in (local_line[c]),
            .bell_in  (bell_line[c]),
            .en_q     (en_q),
            .route_q  (route_q),
            .mask_row (mask_q[c]),
            .pend_any (pend_any[c]),
            .ack_id   (ack_ids[c])
        );
    end

    always_comb begin
        rd_mux = '0;
        unique case (dec.rsel)
            RD_CTRL:  rd_mux[11:2] = ID_W'(NUM_SRC);
            RD_ACK:   rd_mux[ID_W-1:0] = ack_ids[req_cpu];
            RD_ROUTE: if (int'(dec.aidx) < NUM_SRC)
                          rd_mux[NUM_CPU-1:0] = route_q[dec.aidx[SRC_W-1:0]];
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            irq_q       <= '0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_data_q  <= req_valid ? rd_mux : '0;
            irq_q       <= pend_any;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_data_q;
    assign cpu_irq   = irq_q;

endmodule

// File: rtl/mcic_chk.sv
module mcic_chk
    import mcic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             req_valid,
    input logic                             req_write,
    input logic [CPU_W-1:0]                 req_cpu,
    input logic [12:0]                      req_addr,
    input logic [31:0]                      req_wdata,
    input logic                             rsp_valid,
    input logic [31:0]                      rsp_rdata,
    input logic [NUM_CPU-1:0]               cpu_irq,
    input logic [NUM_SRC-1:0]               en_q,
    input logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask_q,
    input logic [NUM_CPU-1:0]               pend_any
);

    logic ack_rd_q;
    logic en_set_hit;
    logic msk_set_hit;

    always_ff @(posedge clk) begin
        if (rst) ack_rd_q <= 1'b0;
        else     ack_rd_q <= req_valid && !req_write && req_addr == {1'b1, OFF_ACK};
    end

    assign en_set_hit  = req_valid && req_write && req_addr == {1'b0, OFF_EN_SET}
                         && req_wdata < NUM_SRC && req_wdata != 0;
    assign msk_set_hit = req_valid && req_write && req_addr == {1'b1, OFF_MSK_SET}
                         && req_wdata < NUM_SRC;

    a_r10_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r10_no_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r2_enable_set: assert property (@(posedge clk) disable iff (rst)
        en_set_hit |=> en_q[$past(req_wdata[SRC_W-1:0])]);

    a_r3_mask_set: assert property (@(posedge clk) disable iff (rst)
        msk_set_hit |=> mask_q[$past(req_cpu)][$past(req_wdata[SRC_W-1:0])]);

    a_r6_ack_range: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && ack_rd_q) |->
            (rsp_rdata[31:ID_W] == '0 &&
             (rsp_rdata[ID_W-1:0] == ID_NONE || int'(rsp_rdata[ID_W-1:0]) < NUM_SRC)));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
        a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> cpu_irq[c] == $past(pend_any[c]));
    end

endmodule

bind mcic_core mcic_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_cpu   (req_cpu),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .cpu_irq   (cpu_irq),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .pend_any  (pend_any)
);

// File: tb/sim_mcic_core.sv
module sim_mcic_core;

    localparam int NS = 32;
    localparam int NC = 4;
    localparam logic [12:0] A_CTRL = 13'h0000;
    localparam logic [12:0] A_ENS  = 13'h0030;
    localparam logic [12:0] A_ENC  = 13'h0034;
    localparam logic [12:0] A_ACK  = 13'h1044;
    localparam logic [12:0] A_MS   = 13'h1048;
    localparam logic [12:0] A_MC   = 13'h104C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_line = '0;
    logic [NC-1:0] local_line = '0;
    logic [NC-1:0] bell_line = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [1:0]    req_cpu = '0;
    logic [12:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NC-1:0] cpu_irq;

    always #4 clk = ~clk;

    mcic_core u0 (
        .clk(clk), .rst(rst), .src_line(src_line), .local_line(local_line),
        .bell_line(bell_line), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_cpu(req_cpu), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cpu_irq(cpu_irq)
    );

    bit       m_en [NS];
    bit [3:0] m_route [NS];
    bit       m_mask [NC][NS];
    int       n_chk = 0;
    int       n_bad = 0;
    bit       done = 0;

    function automatic int exp_ack(int c);
        if (bell_line[c]) return 0;
        for (int s = 1; s < NS; s++) begin
            if (s == 5) begin
                if (local_line[c] && !m_mask[c][5]) return 5;
            end else if (src_line[s] && m_en[s] && m_route[s][c] && !m_mask[c][s]) begin
                return s;
            end
        end
        return 1023;
    endfunction

    task automatic chk(bit ok, string rq, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic bus_write(int c, logic [12:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_cpu = 2'(c);
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (a == A_ENS && d < NS && d != 0) m_en[d] = 1'b1;
        if (a == A_ENC && d < NS && d != 0) m_en[d] = 1'b0;
        if (a == A_MS && d < NS) m_mask[c][d] = 1'b1;
        if (a == A_MC && d < NS) m_mask[c][d] = 1'b0;
        if (a >= 13'h0100 && a < 13'h0100 + 4 * NS) m_route[(a - 13'h0100) >> 2] = d[3:0];
    endtask

    task automatic bus_read(int c, logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_cpu = 2'(c); req_addr = a;
        @(negedge clk);
        chk(rsp_valid && req_ready, "R10", int'(rsp_valid), 1);
        d = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic check_all(string rq);
        logic [31:0] d;
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            chk(cpu_irq[c] == (exp_ack(c) != 1023), {rq, "/R9"}, int'(cpu_irq[c]),
                int'(exp_ack(c) != 1023));
            bus_read(c, A_ACK, d);
            chk(d == 32'(exp_ack(c)), {rq, "/R6"}, int'(d), exp_ack(c));
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd11));
        for (int s = 0; s < NS; s++) for (int c = 0; c < NC; c++) m_mask[c][s] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        chk(cpu_irq == '0, "R1", int'(cpu_irq), 0);
        bus_read(0, A_CTRL, d);
        chk(d == 32'(NS << 2), "R1", int'(d), NS << 2);
        src_line = '1; local_line = '1;
        check_all("R1");
        src_line = '0; local_line = '0;

        // R4: route readback
        bus_write(0, 13'h0100 + 4 * 3, 32'hFFFF_FFF2);
        bus_read(1, 13'h0100 + 4 * 3, d);
        chk(d == 32'h2, "R4", int'(d), 2);

        // R5 / R9: all four conditions and output timing
        src_line[3] = 1'b1;
        bus_write(0, A_ENS, 3);
        check_all("R5");
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_cpu = 2'd1; req_addr = A_MC; req_wdata = 3;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; m_mask[1][3] = 1'b0;
        chk(cpu_irq[1] == 1'b0, "R9", int'(cpu_irq[1]), 0);
        @(negedge clk);
        chk(cpu_irq[1] == 1'b1, "R9", int'(cpu_irq[1]), 1);
        check_all("R5");
        @(negedge clk);
        src_line[3] = 1'b0;
        @(negedge clk);
        chk(cpu_irq[1] == 1'b0, "R9", int'(cpu_irq[1]), 0);
        src_line[3] = 1'b1;

        // R3: mask on one CPU leaves others alone
        bus_write(0, 13'h0100 + 4 * 3, 32'h3);
        bus_write(0, A_MC, 3);
        bus_write(1, A_MS, 3);
        check_all("R3");

        // R2: out-of-range and zero numbers ignored; clear works
        bus_write(0, A_ENS, 40);
        bus_write(0, A_ENS, 0);
        check_all("R2");
        bus_write(0, A_ENC, 3);
        check_all("R2");
        bus_write(0, A_ENS, 3);

        // R6: lowest wins, read is side-effect free
        for (int s = 2; s <= 9; s += 5) begin
            bus_write(0, 13'h0100 + 4 * s, 32'h1);
            bus_write(0, A_ENS, s);
            bus_write(0, A_MC, s);
            src_line[s] = 1'b1;
        end
        check_all("R6");
        bus_read(0, A_ACK, d);
        chk(d == 2, "R6", int'(d), 2);

        // R7: doorbell beats everything
        bell_line[0] = 1'b1;
        check_all("R7");
        bell_line[0] = 1'b0;

        // R8: private source ignores enable and routing
        src_line[5] = 1'b1;
        bus_write(0, A_ENS, 5);
        bus_write(0, 13'h0100 + 4 * 5, 32'hF);
        bus_write(2, A_MC, 5);
        check_all("R8");
        local_line[2] = 1'b1;
        bus_write(0, A_ENC, 5);
        bus_write(0, 13'h0100 + 4 * 5, 32'h0);
        check_all("R8");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            int c;
            op = int'($urandom % 6);
            c  = int'($urandom % NC);
            unique case (op)
                0: bus_write(c, A_ENS, $urandom % 40);
                1: bus_write(c, A_ENC, $urandom % 40);
                2: bus_write(c, A_MS, $urandom % 40);
                3: bus_write(c, A_MC, $urandom % 36);
                4: bus_write(c, 13'(13'h0100 + 4 * ($urandom % NS)), $urandom);
                default: begin
                    src_line   = $urandom;
                    local_line = 4'($urandom);
                    bell_line  = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
                end
            endcase
            check_all("R5");
        end

        done = 1;
        finish_run();
    end

endmodule